// File: doc/BRIEF.md
# Interval Countdown Alarm

The block is an alarm that measures a relative interval rather than matching a calendar value. Software loads a single countdown word that holds days, hours, minutes and seconds in separate fields. While the counter enable is set, each pulse on the one-second tick input subtracts one second, and borrows ripple upward through the mixed-radix fields. On the step that takes the count from one second to zero, the block sets a pending flag and stops counting. That flag drives the interrupt line whenever the interrupt enable is set.

Software converts absolute alarm times into intervals before it writes them. A small register interface provides the countdown word, the counter enable, the interrupt enable and a pending flag that is cleared by writing a one. Reads are combinational on the addressed register.

Top module: `rcat_alarm`

## Requirements
- R1: The countdown register at offset 0x0C holds seconds in bits 5:0, minutes in bits 13:8, hours in bits 20:16 and days in bits 28:21. All other bits read as zero, and writing zero reads back as zero.
- R2: Each cycle in which the tick input is high and the counter enable is set takes one second off a nonzero count. Cycles without a tick leave the count unchanged.
- R3: Decrementing a field that is already at zero reloads it with 59 for seconds or minutes, or 23 for hours, and takes one from the next field up.
- R4: The step from one second remaining to zero sets the pending flag (bit 0 at offset 0x1C) on the same clock edge. The count then stays at zero.
- R5: A zero interval never sets the pending flag, even when the counter is enabled and ticks arrive.
- R6: The interrupt output is high exactly when the pending flag and the interrupt enable (bit 0 at offset 0x18) are both set.
- R7: Writing 1 to bit 0 at offset 0x1C clears the pending flag. Writing 0 there leaves it unchanged.
- R8: If a clear of the pending flag is written in the same cycle as an expiry, the flag stays set.
- R9: When the counter enable (bit 8 at offset 0x14) is clear, ticks do not change the count and the pending flag is unchanged.
- R10: Offset 0x14 reads back only bit 8, and offset 0x18 reads back only bit 0. All registers are zero after reset.
- R11: A write to the countdown register in the same cycle as a tick loads the written value, and that tick is not applied.
- R12: The largest interval, 255 days, loads and counts down correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W (5) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data of the addressed register |
| alarm_irq | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: an 8-bit day field and a 5-bit address. With an 8-bit day field the 255-day maximum is reachable, so the bench loads it and checks the borrow from days all the way down to seconds. Random intervals are compared against a reference that works in total seconds and converts back to fields. Short random intervals are kept small so that expiry, the interrupt mask and clears that collide with an expiry all occur within a run of a few hundred cycles.

// File: rtl/rcat_pkg.sv
package rcat_pkg;
  localparam int SEC_LSB = 0;
  localparam int MIN_LSB = 8;
  localparam int HR_LSB  = 16;
  localparam int DAY_LSB = 21;
  localparam int SEC_W   = 6;
  localparam int MIN_W   = 6;
  localparam int HR_W    = 5;

  localparam logic [7:0] OFS_COUNT = 8'h0C;
  localparam logic [7:0] OFS_CTRL  = 8'h14;
  localparam logic [7:0] OFS_IEN   = 8'h18;
  localparam logic [7:0] OFS_PEND  = 8'h1C;
  localparam int CTRL_EN_BIT = 8;

  // One digit of the mixed-radix count: returns {borrow, next value}.
  function automatic logic [6:0] unit_step(input logic [5:0] v, input logic [5:0] reload);
    if (v == 6'd0) return {1'b1, reload};
    return {1'b0, v - 6'd1};
  endfunction
endpackage

// File: rtl/rcat_countdown.sv
module rcat_countdown #(
  parameter int DAY_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_word,
  input  logic              run,
  output logic [DATA_W-1:0] count_word,
  output logic              expire,
  output logic              at_zero
);
  import rcat_pkg::*;

  logic [SEC_W-1:0] sec_q, sec_n;
  logic [MIN_W-1:0] min_q, min_n;
  logic [HR_W-1:0]  hr_q,  hr_n;
  logic [DAY_W-1:0] day_q, day_n;
  logic [6:0] s_step, m_step, h_step;
  logic last_sec, step;
  logic unused_bits;

  assign unused_bits = ^load_word;

  always_comb begin
    s_step = unit_step(sec_q, 6'd59);
    m_step = s_step[6] ? unit_step(min_q, 6'd59) : {1'b0, min_q};
    h_step = m_step[6] ? unit_step({1'b0, hr_q}, 6'd23) : {2'b00, hr_q};
    sec_n  = s_step[5:0];
    min_n  = m_step[5:0];
    hr_n   = h_step[4:0];
    day_n  = h_step[6] ? day_q - 1'b1 : day_q;
  end

  assign at_zero  = (sec_q == '0) && (min_q == '0) && (hr_q == '0) && (day_q == '0);
  assign last_sec = (sec_q == 6'd1) && (min_q == '0) && (hr_q == '0) && (day_q == '0);
  assign step     = run && !load && !at_zero;
  assign expire   = step && last_sec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      min_q <= '0;
      hr_q  <= '0;
      day_q <= '0;
    end else if (load) begin
      sec_q <= load_word[SEC_LSB +: SEC_W];
      min_q <= load_word[MIN_LSB +: MIN_W];
      hr_q  <= load_word[HR_LSB  +: HR_W];
      day_q <= load_word[DAY_LSB +: DAY_W];
    end else if (step) begin
      sec_q <= sec_n;
      min_q <= min_n;
      hr_q  <= hr_n;
      day_q <= day_n;
    end
  end

  always_comb begin
    count_word = '0;
    count_word[SEC_LSB +: SEC_W] = sec_q;
    count_word[MIN_LSB +: MIN_W] = min_q;
    count_word[HR_LSB  +: HR_W]  = hr_q;
    count_word[DAY_LSB +: DAY_W] = day_q;
  end

  AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n) (at_zero && !load) |=> at_zero); // R5
  AST_EXPIRE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) expire |=> at_zero); // R4
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (!run && !load) |=> $stable(count_word)); // R9
  AST_SEC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n) (step && sec_q == '0) |=> (sec_q == 6'd59)); // R3
endmodule

// File: rtl/rcat_regs.sv
module rcat_regs #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] count_word,
  input  logic              expire,
  output logic              load,
  output logic [DATA_W-1:0] load_word,
  output logic              cnt_en,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import rcat_pkg::*;

  logic irq_en, pending;
  logic sel_count, sel_ctrl, sel_ien, sel_pend, clr;

  assign sel_count = (bus_addr == ADDR_W'(OFS_COUNT));
  assign sel_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
  assign sel_ien   = (bus_addr == ADDR_W'(OFS_IEN));
  assign sel_pend  = (bus_addr == ADDR_W'(OFS_PEND));

  assign load      = bus_wr && sel_count;
  assign load_word = bus_wdata;
  assign clr       = bus_wr && sel_pend && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_en  <= 1'b0;
      irq_en  <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (bus_wr && sel_ctrl) cnt_en <= bus_wdata[CTRL_EN_BIT];
      if (bus_wr && sel_ien)  irq_en <= bus_wdata[0];
      if (expire)             pending <= 1'b1;
      else if (clr)           pending <= 1'b0;
    end
  end

  assign irq = pending && irq_en;

  always_comb begin
    bus_rdata = '0;
    if (sel_count)     bus_rdata = count_word;
    else if (sel_ctrl) bus_rdata[CTRL_EN_BIT] = cnt_en;
    else if (sel_ien)  bus_rdata[0] = irq_en;
    else if (sel_pend) bus_rdata[0] = pending;
  end

  AST_PEND_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) $rose(pending) |-> $past(expire)); // R4
  AST_EXPIRE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) expire |=> pending); // R8
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!expire && !clr) |=> (pending == $past(pending))); // R9
endmodule

// File: rtl/rcat_alarm.sv
module rcat_alarm #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int DAY_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              alarm_irq
);
  logic              load, cnt_en, expire, at_zero, run;
  logic [DATA_W-1:0] load_word, count_word;

  assign run = tick_1hz && cnt_en;

  rcat_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .count_word(count_word), .expire(expire),
    .load(load), .load_word(load_word), .cnt_en(cnt_en),
    .bus_rdata(bus_rdata), .irq(alarm_irq)
  );

  rcat_countdown #(.DAY_W(DAY_W), .DATA_W(DATA_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load(load), .load_word(load_word),
    .run(run), .count_word(count_word), .expire(expire), .at_zero(at_zero)
  );

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n) $rose(alarm_irq) |-> !at_zero || $past(expire) || $past(bus_wr)); // R6
endmodule

// File: tb/rcat_alarm_bench.sv
module rcat_alarm_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_CNT = 5'h0C, A_CTL = 5'h14, A_IEN = 5'h18, A_PND = 5'h1C;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr = 1'b0;
  logic [4:0] addr = A_CNT;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;
  int n_chk = 0, n_bad = 0, cyc_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rcat_alarm u_rcat_alarm (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .alarm_irq(irq)
  );

  function automatic int to_secs(input logic [31:0] w);
    return ((int'(w[28:21]) * 24 + int'(w[20:16])) * 60 + int'(w[13:8])) * 60 + int'(w[5:0]);
  endfunction

  function automatic logic [31:0] from_secs(input int t);
    logic [31:0] w = '0;
    w[5:0]   = 6'(t % 60);
    w[13:8]  = 6'((t / 60) % 60);
    w[20:16] = 5'((t / 3600) % 24);
    w[28:21] = 8'(t / 86400);
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(input bit w, input logic [4:0] a, input logic [31:0] d, input bit t);
    wr = w; addr = a; wdata = d; tick = t;
    @(negedge clk);
    wr = 1'b0; tick = 1'b0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d expected below 20000 cycles", cyc_cnt);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int exp_t;
    bit exp_en, exp_ien, exp_pend;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 / R1 reset state
    peek(A_CNT, v); chk("R1 reset count", v, 32'h0);
    peek(A_CTL, v); chk("R10 reset ctrl", v, 32'h0);
    peek(A_IEN, v); chk("R10 reset ien", v, 32'h0);
    peek(A_PND, v); chk("R10 reset pend", v, 32'h0);
    chk("R6 reset irq", {31'b0, irq}, 32'h0);

    // R1 field masking and zero write
    cyc(1, A_CNT, 32'hFFFF_FFFF, 0);
    peek(A_CNT, v); chk("R1 mask", v, 32'h1FFF_3F3F);
    cyc(1, A_CNT, 32'h0, 0);
    peek(A_CNT, v); chk("R1 zero write", v, 32'h0);

    // R10 control readback
    cyc(1, A_CTL, 32'hFFFF_FFFF, 0);
    peek(A_CTL, v); chk("R10 ctrl bit8", v, 32'h100);
    cyc(1, A_IEN, 32'hFFFF_FFFF, 0);
    peek(A_IEN, v); chk("R10 ien bit0", v, 32'h1);

    // R5 zero interval never fires
    repeat (4) cyc(0, A_CNT, 0, 1);
    peek(A_PND, v); chk("R5 zero no pend", v, 32'h0);
    peek(A_CNT, v); chk("R5 zero stays", v, 32'h0);

    // R3 borrow from days
    cyc(1, A_CNT, 32'h0020_0000, 0);
    cyc(0, A_CNT, 0, 1);
    peek(A_CNT, v); chk("R3 borrow", v, (32'd23 << 16) | (32'd59 << 8) | 32'd59);

    // R12 maximum interval
    cyc(1, A_CNT, 32'd255 << 21, 0);
    cyc(0, A_CNT, 0, 1);
    peek(A_CNT, v); chk("R12 max", v, (32'd254 << 21) | (32'd23 << 16) | (32'd59 << 8) | 32'd59);

    // R2 no tick no change
    cyc(1, A_CNT, 32'd5, 0);
    repeat (3) cyc(0, A_CNT, 0, 0);
    peek(A_CNT, v); chk("R2 idle", v, 32'd5);
    cyc(0, A_CNT, 0, 1);
    peek(A_CNT, v); chk("R2 step", v, 32'd4);

    // R11 load beats tick
    cyc(1, A_CNT, 32'd10, 1);
    peek(A_CNT, v); chk("R11 load wins", v, 32'd10);

    // R4 expiry, R6 irq
    cyc(1, A_CNT, 32'd2, 0);
    cyc(0, A_CNT, 0, 1);
    peek(A_PND, v); chk("R4 not yet", v, 32'h0);
    cyc(0, A_CNT, 0, 1);
    peek(A_PND, v); chk("R4 pend set", v, 32'h1);
    peek(A_CNT, v); chk("R4 zero", v, 32'h0);
    chk("R6 irq on", {31'b0, irq}, 32'h1);
    repeat (3) cyc(0, A_CNT, 0, 1);
    peek(A_CNT, v); chk("R4 stays zero", v, 32'h0);
    cyc(1, A_IEN, 32'h0, 0);
    chk("R6 irq masked", {31'b0, irq}, 32'h0);
    cyc(1, A_IEN, 32'h1, 0);

    // R7 clear semantics
    cyc(1, A_PND, 32'h0, 0);
    peek(A_PND, v); chk("R7 write0 keeps", v, 32'h1);
    cyc(1, A_PND, 32'h1, 0);
    peek(A_PND, v); chk("R7 w1c", v, 32'h0);
    chk("R6 irq off", {31'b0, irq}, 32'h0);

    // R8 clear collides with expiry
    cyc(1, A_CNT, 32'd1, 0);
    cyc(1, A_PND, 32'h1, 1);
    peek(A_PND, v); chk("R8 expiry wins", v, 32'h1);

    // R9 freeze
    cyc(1, A_CNT, 32'd5, 0);
    cyc(1, A_CTL, 32'h0, 0);
    repeat (4) cyc(0, A_CNT, 0, 1);
    peek(A_CNT, v); chk("R9 frozen", v, 32'd5);
    peek(A_PND, v); chk("R9 pend kept", v, 32'h1);
    cyc(1, A_PND, 32'h1, 0);

    // Random trials against a total-seconds reference (R2 R3 R4 R6 R9)
    for (int tr = 0; tr < 30; tr++) begin
      if ($urandom % 2 == 0) exp_t = 1 + int'($urandom % 8);
      else exp_t = to_secs({3'b0, 8'($urandom % 3), 5'($urandom % 24), 2'b0, 6'($urandom % 60), 2'b0, 6'($urandom % 60)});
      exp_en = 1; exp_ien = bit'($urandom % 2); exp_pend = 0;
      cyc(1, A_PND, 32'h1, 0);
      cyc(1, A_CNT, from_secs(exp_t), 0);
      cyc(1, A_IEN, {31'b0, exp_ien}, 0);
      cyc(1, A_CTL, 32'h100, 0);
      for (int k = 0; k < 14; k++) begin
        bit t = bit'($urandom % 2);
        bit tog = ($urandom % 8) == 0;
        if (tog) cyc(1, A_CTL, {23'b0, !exp_en, 8'b0}, t);
        else cyc(0, A_CNT, 0, t);
        if (t && exp_en && exp_t > 0) begin
          exp_t--;
          if (exp_t == 0) exp_pend = 1;
        end
        if (tog) exp_en = !exp_en;
        peek(A_CNT, v); chk("R3 random count", v, from_secs(exp_t));
        chk("R6 random irq", {31'b0, irq}, {31'b0, exp_pend & exp_ien});
      end
      peek(A_PND, v); chk("R4 random pend", v, {31'b0, exp_pend});
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule